// File: doc/BRIEF.md
# Continuous ADC Conversion Sequencer

This block sequences a 10-bit successive-approximation converter. Software writes a 7-bit control word holding a start bit, a repeat-mode bit, a reference-power bit and a 4-bit source selector. The block then counts system clock cycles until the first result is due. At that edge it latches the converter's 10-bit output bus into two 8-bit data registers, with the result left-aligned, and raises a one-cycle interrupt request.

The first conversion is long and fixed: 5129 cycles. When the reference was not already powered, 40 power-up cycles come before it. In repeat mode every later result follows exactly 256 cycles after the previous one. The start bit drops back to 0 when the first result lands and does not come back while repeats continue. Clearing the repeat bit ends the run at the next period boundary, and the conversion already in progress still delivers its result. The analog front end, the reference generator and any filtering are outside the block. The converter core is modelled as a digital input bus that is sampled at the completion edge.

Top module: `adc_seq_top`

## Requirements
- R1: After a synchronous active-low reset, the control readback, both data registers, `irq` and `ref_on` are 0 and no conversion is running. A reset during a conversion abandons that conversion, and no result follows.
- R2: A write stores bit 5 as the repeat bit, bit 4 as the reference bit and bits 3:0 as the source selector. `ctrl_rd` returns {start, repeat, reference, selector} in bits 6, 5, 4 and 3:0. `ref_on` follows bit 4 and `ain_sel` follows bits 3:0.
- R3: When the reference bit was 1 before the write, a write with bit 6 set, a selector of 0 to 4 and no conversion running starts a conversion. Its first result lands on the 5129th clock edge after the write edge.
- R4: When the reference bit was 0 before that starting write, the first result lands on the 5169th edge after the write edge, which includes 40 power-up cycles.
- R5: A write with bit 6 set and a selector of 5 to 15 starts nothing. Bit 6 reads 0 and no result follows.
- R6: At each completion edge the 10-bit input s is stored as `data_hi` = s[9:2] and `data_lo` = {s[1:0], 6'b0}. Both registers change on that same edge and hold their values between completions.
- R7: `irq` is high for exactly the one cycle that follows each completion edge, and is low at all other times.
- R8: Bit 6 of `ctrl_rd` reads 1 from the starting write until the first completion edge. It reads 0 from then on, including during repeated conversions.
- R9: While the repeat bit is 1, each result after the first lands 256 edges after the previous one.
- R10: When the repeat bit is cleared, the pending conversion still completes at its normal edge and raises `irq`. After that, no further results occur.
- R11: A write with bit 6 set while a conversion is running does not restart it or move its completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 7 | Control word: start, repeat, reference, selector |
| sample_in | input | 10 | Converter core output bus |
| ctrl_rd | output | 7 | Control register readback |
| data_hi | output | 8 | Result bits 9:2 |
| data_lo | output | 8 | Result bits 1:0 in bits 7:6, zeros below |
| irq | output | 1 | One-cycle conversion-complete request |
| ref_on | output | 1 | Reference power enable |
| ain_sel | output | 4 | Selected analog source |

## Verification
For a write sampled on edge T, the control readback, `ref_on` and `ain_sel` change after edge T. The first result lands on edge T+5129, or T+5169 with power-up, and then every 256 edges. Both data registers change on that edge, and `irq` is high in the cycle that follows it. A behavioural model in the bench takes the same clock edges as the design and keeps an absolute due-edge number for the next result. All outputs are compared at the falling edge, when they are settled. In directed checks, the edge index of every `irq` cycle is compared with the write edge plus the cycle counts from the requirements.

// File: rtl/adc_seq_pkg.sv
// Shared types for the ADC conversion sequencer.
// Assumes a 7-bit control word with the field order of ctrl_t (start at the top).
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PWRUP  = 2'd1,
        ST_FIRST  = 2'd2,
        ST_REPEAT = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic       start;
        logic       rpt;
        logic       refon;
        logic [3:0] sel;
    } ctrl_t;

endpackage

// File: rtl/adc_ctrl_reg.sv
// Control register for the sequencer.
// Stores the repeat, reference and selector fields on every write. The start
// bit is set only by a valid start (idle and legal selector), and it clears
// at the first completion. Assumes first_done_i is never high while idle_i is.
module adc_ctrl_reg
    import adc_seq_pkg::*;
#(
    parameter int NUM_SRC = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [6:0] wr_data,
    input  logic       idle_i,
    input  logic       first_done_i,
    output ctrl_t      ctrl_o,
    output logic       start_o,
    output logic       pwr_needed_o
);
    localparam int SELW = 4;

    ctrl_t ctrl_q;
    ctrl_t wr_word;

    // Decode the incoming word and qualify a start request.
    always_comb begin
        wr_word      = ctrl_t'(wr_data);
        start_o      = wr_en && wr_word.start && idle_i && (wr_word.sel < SELW'(NUM_SRC));
        pwr_needed_o = !ctrl_q.refon;
    end

    // Update the register fields and the self-clearing start bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (first_done_i) ctrl_q.start <= 1'b0;
            if (wr_en) begin
                ctrl_q.rpt   <= wr_word.rpt;
                ctrl_q.refon <= wr_word.refon;
                ctrl_q.sel   <= wr_word.sel;
                if (start_o) ctrl_q.start <= 1'b1;
            end
        end
    end

    assign ctrl_o = ctrl_q;

    assert_start_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        first_done_i |=> !ctrl_q.start);

    assert_reserved_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[3:0] >= SELW'(NUM_SRC) && !ctrl_q.start) |=> !ctrl_q.start);

endmodule

// File: rtl/adc_timer.sv
// Conversion timer: power-up wait, long first conversion, short repeat period.
// Assumes FIRST_CYCLES and PERIOD_CYCLES are at least 2. A PWRUP_CYCLES of 0
// skips the power-up phase.
module adc_timer
    import adc_seq_pkg::*;
#(
    parameter int FIRST_CYCLES  = 5129,
    parameter int PWRUP_CYCLES  = 40,
    parameter int PERIOD_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic pwr_needed_i,
    input  logic rpt_i,
    output logic idle_o,
    output logic done_o,
    output logic first_done_o
);
    localparam int MAXA = (FIRST_CYCLES > PWRUP_CYCLES) ? FIRST_CYCLES : PWRUP_CYCLES;
    localparam int MAXC = (MAXA > PERIOD_CYCLES) ? MAXA : PERIOD_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_t      state;
    logic [CW-1:0]   cnt;
    logic            cnt_zero;

    // Decode the phase outputs from state and count.
    always_comb begin
        cnt_zero     = (cnt == '0);
        idle_o       = (state == ST_IDLE);
        done_o       = ((state == ST_FIRST) || (state == ST_REPEAT)) && cnt_zero;
        first_done_o = (state == ST_FIRST) && cnt_zero;
    end

    // Step the phase machine and its down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        if (pwr_needed_i && PWRUP_CYCLES > 0) begin
                            state <= ST_PWRUP;
                            cnt   <= CW'(PWRUP_CYCLES - 1);
                        end else begin
                            state <= ST_FIRST;
                            cnt   <= CW'(FIRST_CYCLES - 1);
                        end
                    end
                end
                ST_PWRUP: begin
                    if (cnt_zero) begin
                        state <= ST_FIRST;
                        cnt   <= CW'(FIRST_CYCLES - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_FIRST, ST_REPEAT: begin
                    if (cnt_zero) begin
                        if (rpt_i) begin
                            state <= ST_REPEAT;
                            cnt   <= CW'(PERIOD_CYCLES - 1);
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_first_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRST) |-> (cnt < CW'(FIRST_CYCLES)));

    assert_repeat_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPEAT) |-> (cnt < CW'(PERIOD_CYCLES)));

    assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (state == ST_IDLE));

endmodule

// File: rtl/adc_result_reg.sv
// Result capture: stores the converter bus left-aligned across two data
// registers on the completion edge and pulses the interrupt for one cycle.
// Assumes RES_W > DW and that completions are at least two cycles apart.
module adc_result_reg #(
    parameter int RES_W = 10,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic [RES_W-1:0] sample_i,
    output logic [DW-1:0]    data_hi,
    output logic [DW-1:0]    data_lo,
    output logic             irq
);
    localparam int LOW_BITS = RES_W - DW;
    localparam int PAD_BITS = DW - LOW_BITS;

    // Latch both halves together and raise the request one cycle after completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_hi <= '0;
            data_lo <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= done_i;
            if (done_i) begin
                data_hi <= sample_i[RES_W-1:LOW_BITS];
                data_lo <= {sample_i[LOW_BITS-1:0], {PAD_BITS{1'b0}}};
            end
        end
    end

    assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable({data_hi, data_lo}));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

endmodule

// File: rtl/adc_seq_top.sv
// Top of the ADC conversion sequencer: control register, timer, result capture.
// Assumes a single clock domain and a converter bus that is stable at the completion edge.
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int NUM_SRC       = 5,
    parameter int FIRST_CYCLES  = 5129,
    parameter int PWRUP_CYCLES  = 40,
    parameter int PERIOD_CYCLES = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [6:0] wr_data,
    input  logic [9:0] sample_in,
    output logic [6:0] ctrl_rd,
    output logic [7:0] data_hi,
    output logic [7:0] data_lo,
    output logic       irq,
    output logic       ref_on,
    output logic [3:0] ain_sel
);
    ctrl_t ctrl;
    logic  start, pwr_needed, idle, done, first_done;

    adc_ctrl_reg #(.NUM_SRC(NUM_SRC)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .idle_i       (idle),
        .first_done_i (first_done),
        .ctrl_o       (ctrl),
        .start_o      (start),
        .pwr_needed_o (pwr_needed)
    );

    adc_timer #(
        .FIRST_CYCLES  (FIRST_CYCLES),
        .PWRUP_CYCLES  (PWRUP_CYCLES),
        .PERIOD_CYCLES (PERIOD_CYCLES)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .pwr_needed_i (pwr_needed),
        .rpt_i        (ctrl.rpt),
        .idle_o       (idle),
        .done_o       (done),
        .first_done_o (first_done)
    );

    adc_result_reg #(.RES_W(10), .DW(8)) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (done),
        .sample_i (sample_in),
        .data_hi  (data_hi),
        .data_lo  (data_lo),
        .irq      (irq)
    );

    assign ctrl_rd = ctrl;
    assign ref_on  = ctrl.refon;
    assign ain_sel = ctrl.sel;

    assert_start_only_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.start && !first_done) |=> ctrl.start);

endmodule

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/100ps
module sim_adc_seq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] wr_data = '0;
    logic [9:0] sample_in = '0;
    logic [6:0] ctrl_rd;
    logic [7:0] data_hi, data_lo;
    logic       irq, ref_on;
    logic [3:0] ain_sel;

    adc_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .sample_in(sample_in), .ctrl_rd(ctrl_rd), .data_hi(data_hi),
        .data_lo(data_lo), .irq(irq), .ref_on(ref_on), .ain_sel(ain_sel)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic check(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    longint cyc = 0;
    bit     m_busy = 0, m_first = 0, m_en = 0, m_rpt = 0, m_ref = 0, m_irq = 0;
    bit [3:0] m_sel = 0;
    bit [7:0] m_hi = 0, m_lo = 0;
    longint due = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_first = 0; m_en = 0; m_rpt = 0; m_ref = 0; m_irq = 0;
            m_sel = 0; m_hi = 0; m_lo = 0;
        end else begin
            bit was_busy, old_rpt, old_ref;
            was_busy = m_busy; old_rpt = m_rpt; old_ref = m_ref;
            m_irq = 0;
            if (m_busy && cyc == due) begin
                m_hi = sample_in[9:2];
                m_lo = {sample_in[1:0], 6'b0};
                m_irq = 1;
                if (m_first) begin m_en = 0; m_first = 0; end
                if (old_rpt) due = cyc + 256;
                else m_busy = 0;
            end
            if (wr_en) begin
                m_rpt = wr_data[5]; m_ref = wr_data[4]; m_sel = wr_data[3:0];
                if (!was_busy && wr_data[6] && wr_data[3:0] <= 4) begin
                    m_busy = 1; m_first = 1; m_en = 1;
                    due = cyc + 5129 + (old_ref ? 0 : 40);
                end
            end
        end
        cyc++;
    end

    // Compare every cycle at the falling edge; log the edge index of each irq.
    longint irq_q[$];
    always @(negedge clk) begin
        if (cyc > 0 && !finished) begin
            check("R8", "start bit", ctrl_rd[6], m_en);
            check("R2", "ctrl fields", ctrl_rd[5:0], {m_rpt, m_ref, m_sel});
            check("R2", "ref_on", ref_on, m_ref);
            check("R2", "ain_sel", ain_sel, m_sel);
            check("R6", "data_hi", data_hi, m_hi);
            check("R6", "data_lo", data_lo, m_lo);
            check("R7", "irq", irq, m_irq);
            if (irq) irq_q.push_back(cyc - 1);
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one write; returns the edge index that samples it.
    task automatic wr(input logic [6:0] d, output longint edge_idx);
        @(negedge clk);
        wr_en = 1; wr_data = d; edge_idx = cyc;
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        repeat (20000 * 10) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        longint s, w, d;
        int k_last;
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(1);
        // R1 reset state
        check("R1", "reset outputs", {ctrl_rd, data_hi, data_lo, irq, ref_on}, 0);

        // R4: start with reference off, single conversion
        sample_in = 10'h2B5;
        irq_q.delete();
        wr(7'b1000010, s);
        wait_cyc(5300);
        check("R4", "irq count", irq_q.size(), 1);
        if (irq_q.size() > 0) check("R4", "first result edge", irq_q[0], s + 5169);
        check("R6", "hi value", data_hi, 8'hAD);
        check("R6", "lo value", data_lo, 8'h40);

        // R3 and R11: reference already on, restart attempt mid-run
        wr(7'b0010001, d);
        wait_cyc(5);
        sample_in = 10'h0C3;
        irq_q.delete();
        wr(7'b1010001, s);
        wait_cyc(1000);
        wr(7'b1010001, d);
        wait_cyc(4300);
        check("R3", "irq count", irq_q.size(), 1);
        if (irq_q.size() > 0) check("R3", "first result edge", irq_q[0], s + 5129);
        if (irq_q.size() > 0) check("R11", "edge not moved", irq_q[0], s + 5129);
        check("R6", "hi value 2", data_hi, 8'h30);
        check("R6", "lo value 2", data_lo, 8'hC0);

        // R9, R10, R8: repeat mode with a changing input, then stop
        irq_q.delete();
        wr(7'b1110011, s);
        for (int i = 0; i < 5129 + 256 * 3 + 100; i++) begin
            @(negedge clk);
            sample_in = 10'(cyc * 7 + 3);
        end
        check("R8", "start bit low in repeats", ctrl_rd[6], 0);
        wr(7'b0010011, w);
        wait_cyc(700);
        k_last = 0;
        while (s + 5129 + 256 * k_last <= w) k_last++;
        check("R10", "result count", irq_q.size(), k_last + 1);
        for (int k = 0; k < irq_q.size(); k++)
            check("R9", "repeat edge", irq_q[k], s + 5129 + 256 * k);

        // R5: reserved selector
        irq_q.delete();
        wr(7'b1010111, d);
        check("R5", "start bit", ctrl_rd[6], 0);
        wait_cyc(5300);
        check("R5", "no result", irq_q.size(), 0);

        // R1: reset during a conversion
        wr(7'b1010010, d);
        wait_cyc(100);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        irq_q.delete();
        check("R1", "mid-run reset", {ctrl_rd, data_hi, data_lo, irq, ref_on}, 0);
        wait_cyc(5300);
        check("R1", "no result after reset", irq_q.size(), 0);

        finished = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule